// File: doc/BRIEF.md
# Segmented Fetch Address Unit

This block keeps the code segment and the instruction pointer of a 16-bit processor front end and turns them into the 20-bit physical address used for instruction fetch. The physical address is the segment moved up four bit positions plus the offset. This lets a machine whose offsets are only 16 bits wide reach a 1 MB space. The fetch engine advances the offset by the number of bytes it has consumed. The execution side loads a fresh segment and offset pair for a far transfer of control. Each such load raises a one-cycle strobe that tells the prefetch queue to discard its contents.

The block also qualifies the board-level reset pin. A reset is taken only once the pin has stayed high for a programmable number of consecutive clock cycles, four by default. A taken reset places the segment at all ones and the offset at zero, so the first fetch comes from 16 bytes below the top of the address space. It also clears the interrupt-enable flag. That flag is set and cleared through two dedicated request inputs.

Top module: `fetch_addr_unit`

## Requirements
- R1: A reset is taken only at a rising clock edge where `rst_pin` is sampled high and was also sampled high at the previous three edges (RST_HOLD = 4). A high pulse of three cycles or less leaves `cs_o`, `ip_o` and `int_en_o` unchanged.
- R2: After a taken reset, `cs_o` = 0xFFFF, `ip_o` = 0x0000 and `phys_addr` = 0xFFFF0.
- R3: A taken reset sets `int_en_o` to 0 and `flush_o` to 0.
- R4: `phys_addr` always equals (`cs_o` * 16 + `ip_o`) modulo 2^20, so sums above 0xFFFFF wrap to low addresses.
- R5: With `inc_req` high and `jump_req` low, the edge adds `inc_bytes` (0 to 7) to the offset modulo 2^16 and leaves the segment unchanged.
- R6: With `jump_req` high, the edge loads `jump_seg` into the segment and `jump_off` into the offset. `inc_req` is ignored in that cycle.
- R7: `flush_o` is high in the cycle after each edge that accepts a jump and low after every edge without one. Back-to-back jumps therefore keep it high.
- R8: `int_en_set` makes `int_en_o` 1 at the next edge and `int_en_clr` makes it 0. When both are high, clear wins.
- R9: While a reset is being taken, `jump_req`, `inc_req` and `int_en_set` have no effect. The reset values of R2 and R3 hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_pin | input | 1 | Raw reset pin, active high, qualified by hold time |
| inc_req | input | 1 | Advance the offset |
| inc_bytes | input | 3 | Byte count added to the offset |
| jump_req | input | 1 | Load a new segment and offset |
| jump_seg | input | 16 | New segment value |
| jump_off | input | 16 | New offset value |
| int_en_set | input | 1 | Set the interrupt-enable flag |
| int_en_clr | input | 1 | Clear the interrupt-enable flag (has priority) |
| phys_addr | output | 20 | Physical fetch address |
| cs_o | output | 16 | Current code segment |
| ip_o | output | 16 | Current instruction pointer |
| int_en_o | output | 1 | Interrupt-enable flag |
| flush_o | output | 1 | One-cycle prefetch flush strobe |

## Verification
The bench sends reset pulses of exactly three and exactly four cycles. A filter that is off by one would either take the short pulse and clear the flag, or ignore the real reset and keep stale values. A 64 by 64 sweep of segment and offset pairs includes combinations whose sum passes 0xFFFFF. An adder that kept a 21st bit, or that shifted the segment the wrong way, would give the wrong address there. Offset increments are driven across the 0xFFFF boundary with every byte count, to catch a carry that leaks into the segment. Further cases cover a jump issued together with an increment, back-to-back jumps with the flush strobe, simultaneous set and clear of the flag, and jumps presented while reset is held, which a wrong design would let through.

// File: rtl/fetch_addr_unit.sv
module fetch_addr_unit #(
  parameter int OFF_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int CNT_W     = 3,
  parameter int RST_HOLD  = 4,
  localparam int PHYS_W   = OFF_W + SEG_SHIFT
) (
  input  logic              clk,
  input  logic              rst_pin,
  input  logic              inc_req,
  input  logic [CNT_W-1:0]  inc_bytes,
  input  logic              jump_req,
  input  logic [OFF_W-1:0]  jump_seg,
  input  logic [OFF_W-1:0]  jump_off,
  input  logic              int_en_set,
  input  logic              int_en_clr,
  output logic [PHYS_W-1:0] phys_addr,
  output logic [OFF_W-1:0]  cs_o,
  output logic [OFF_W-1:0]  ip_o,
  output logic              int_en_o,
  output logic              flush_o
);

  logic             rst_take;
  logic [OFF_W-1:0] cs_q, ip_q;
  logic             ie_q, flush_q;

  generate
    if (RST_HOLD <= 1) begin : g_hold1
      assign rst_take = rst_pin;
    end else if (RST_HOLD == 2) begin : g_hold2
      logic prev_q;
      always_ff @(posedge clk) prev_q <= rst_pin;
      assign rst_take = rst_pin & prev_q;
    end else begin : g_holdn
      logic [RST_HOLD-2:0] hist_q;
      always_ff @(posedge clk) hist_q <= {hist_q[RST_HOLD-3:0], rst_pin};
      assign rst_take = rst_pin & (&hist_q);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst_take) begin
      cs_q    <= '1;
      ip_q    <= '0;
      ie_q    <= 1'b0;
      flush_q <= 1'b0;
    end else begin
      flush_q <= jump_req;
      if (jump_req) begin
        cs_q <= jump_seg;
        ip_q <= jump_off;
      end else if (inc_req) begin
        ip_q <= ip_q + OFF_W'(inc_bytes);
      end
      if (int_en_clr)      ie_q <= 1'b0;
      else if (int_en_set) ie_q <= 1'b1;
    end
  end

  assign phys_addr = {cs_q, SEG_SHIFT'(0)} + PHYS_W'(ip_q);
  assign cs_o      = cs_q;
  assign ip_o      = ip_q;
  assign int_en_o  = ie_q;
  assign flush_o   = flush_q;

endmodule

// File: rtl/fetch_addr_unit_chk.sv
module fetch_addr_unit_chk #(
  parameter int OFF_W    = 16,
  parameter int CNT_W    = 3,
  parameter int RST_HOLD = 4
) (
  input logic             clk,
  input logic             rst_pin,
  input logic             inc_req,
  input logic [CNT_W-1:0] inc_bytes,
  input logic             jump_req,
  input logic [OFF_W-1:0] jump_seg,
  input logic [OFF_W-1:0] jump_off,
  input logic             int_en_set,
  input logic             int_en_clr,
  input logic [OFF_W-1:0] cs_o,
  input logic [OFF_W-1:0] ip_o,
  input logic             int_en_o,
  input logic             flush_o
);

  int   high_run = 0;
  logic armed    = 1'b0;
  logic rst_now;

  assign rst_now = rst_pin && (high_run >= RST_HOLD - 1);

  always_ff @(posedge clk) begin
    if (!rst_pin)                  high_run <= 0;
    else if (high_run < RST_HOLD)  high_run <= high_run + 1;
    if (rst_now) armed <= 1'b1;
  end

  AST_RESET_LOAD: assert property (@(posedge clk) disable iff (!armed)
    rst_now |=> (cs_o == '1) && (ip_o == '0)) else $error("reset load"); // R2

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!armed)
    rst_now |=> !int_en_o && !flush_o) else $error("reset clears"); // R3

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!armed)
    (!rst_now && !jump_req && !inc_req && !int_en_set && !int_en_clr)
      |=> $stable(cs_o) && $stable(ip_o) && $stable(int_en_o)) else $error("idle"); // R1

  AST_INC_WRAP: assert property (@(posedge clk) disable iff (!armed)
    (!rst_now && !jump_req && inc_req)
      |=> (ip_o == $past(ip_o) + OFF_W'($past(inc_bytes))) && $stable(cs_o)) else $error("inc"); // R5

  AST_JUMP_LOAD: assert property (@(posedge clk) disable iff (!armed)
    (!rst_now && jump_req)
      |=> (cs_o == $past(jump_seg)) && (ip_o == $past(jump_off))) else $error("jump"); // R6

  AST_FLUSH_AFTER_JUMP: assert property (@(posedge clk) disable iff (!armed)
    (!rst_now && jump_req) |=> flush_o) else $error("flush high"); // R7

  AST_NO_STRAY_FLUSH: assert property (@(posedge clk) disable iff (!armed)
    !jump_req |=> !flush_o) else $error("flush low"); // R7

  AST_IE_CLEAR_WINS: assert property (@(posedge clk) disable iff (!armed)
    (!rst_now && int_en_clr) |=> !int_en_o) else $error("ie clr"); // R8

  AST_IE_SET: assert property (@(posedge clk) disable iff (!armed)
    (!rst_now && int_en_set && !int_en_clr) |=> int_en_o) else $error("ie set"); // R8

endmodule

bind fetch_addr_unit fetch_addr_unit_chk #(
  .OFF_W(OFF_W), .CNT_W(CNT_W), .RST_HOLD(RST_HOLD)
) u_chk (
  .clk(clk), .rst_pin(rst_pin), .inc_req(inc_req), .inc_bytes(inc_bytes),
  .jump_req(jump_req), .jump_seg(jump_seg), .jump_off(jump_off),
  .int_en_set(int_en_set), .int_en_clr(int_en_clr),
  .cs_o(cs_o), .ip_o(ip_o), .int_en_o(int_en_o), .flush_o(flush_o)
);

// File: tb/tb_fetch_addr_unit.sv
module tb_fetch_addr_unit;

  logic        clk = 1'b0;
  logic        rst_pin = 1'b1;
  logic        inc_req = 1'b0;
  logic [2:0]  inc_bytes = '0;
  logic        jump_req = 1'b0;
  logic [15:0] jump_seg = '0;
  logic [15:0] jump_off = '0;
  logic        int_en_set = 1'b0;
  logic        int_en_clr = 1'b0;
  logic [19:0] phys_addr;
  logic [15:0] cs_o, ip_o;
  logic        int_en_o, flush_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  fetch_addr_unit dut (
    .clk(clk), .rst_pin(rst_pin), .inc_req(inc_req), .inc_bytes(inc_bytes),
    .jump_req(jump_req), .jump_seg(jump_seg), .jump_off(jump_off),
    .int_en_set(int_en_set), .int_en_clr(int_en_clr),
    .phys_addr(phys_addr), .cs_o(cs_o), .ip_o(ip_o),
    .int_en_o(int_en_o), .flush_o(flush_o)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] phys_of(input logic [15:0] s, input logic [15:0] o);
    logic [20:0] sum = {1'b0, s, 4'h0} + {5'h0, o};
    return sum[19:0];
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] m_ip;
    repeat (4) step();
    rst_pin = 1'b0;
    chk("R2 cs", cs_o, 32'hFFFF);
    chk("R2 ip", ip_o, 32'h0);
    chk("R2 phys", phys_addr, 32'hFFFF0);
    chk("R3 ie", int_en_o, 0);
    chk("R3 flush", flush_o, 0);

    int_en_set = 1; step();
    chk("R8 set", int_en_o, 1);
    int_en_clr = 1; step();
    chk("R8 clr wins", int_en_o, 0);
    int_en_clr = 0; step();
    chk("R8 set again", int_en_o, 1);
    int_en_set = 0;

    jump_req = 1; jump_seg = 16'h1234; jump_off = 16'h5678; step();
    jump_req = 0; step();
    rst_pin = 1; repeat (3) step();
    rst_pin = 0; step();
    chk("R1 short cs", cs_o, 32'h1234);
    chk("R1 short ip", ip_o, 32'h5678);
    chk("R1 short ie", int_en_o, 1);

    rst_pin = 1; repeat (4) step();
    chk("R1 full cs", cs_o, 32'hFFFF);
    chk("R1 full ie", int_en_o, 0);
    jump_req = 1; jump_seg = 16'h0100; jump_off = 16'h0010;
    inc_req = 1; inc_bytes = 3'd5; int_en_set = 1;
    repeat (2) step();
    chk("R9 cs", cs_o, 32'hFFFF);
    chk("R9 ip", ip_o, 32'h0);
    chk("R9 ie", int_en_o, 0);
    chk("R9 flush", flush_o, 0);
    rst_pin = 0; jump_req = 0; inc_req = 0; int_en_set = 0;

    jump_req = 1; inc_req = 1; inc_bytes = 3'd7;
    jump_seg = 16'hABCD; jump_off = 16'h0100; step();
    chk("R6 cs", cs_o, 32'hABCD);
    chk("R6 ip beats inc", ip_o, 32'h0100);
    chk("R7 flush", flush_o, 1);
    jump_seg = 16'h0042; jump_off = 16'h0003; inc_req = 0; step();
    chk("R6 b2b cs", cs_o, 32'h0042);
    chk("R7 b2b flush", flush_o, 1);
    jump_req = 0; step();
    chk("R7 flush drop", flush_o, 0);

    for (int si = 0; si < 64; si++) begin
      for (int oi = 0; oi < 64; oi++) begin
        logic [15:0] s, o;
        s = 16'hFFFF - 16'(si * 1040);
        o = 16'hFFFF - 16'(oi * 1039);
        jump_req = 1; jump_seg = s; jump_off = o; step();
        chk("R4 phys", phys_addr, {12'h0, phys_of(s, o)});
        chk("R7 sweep flush", flush_o, 1);
      end
    end
    jump_req = 0; step();
    chk("R7 sweep end", flush_o, 0);

    jump_req = 1; jump_seg = 16'h2000; jump_off = 16'hFFF0; step();
    jump_req = 0;
    m_ip = 16'hFFF0;
    inc_req = 1;
    for (int r = 0; r < 4; r++) begin
      for (int c = 0; c < 8; c++) begin
        inc_bytes = 3'(c); step();
        m_ip = m_ip + 16'(c);
        chk("R5 ip", ip_o, {16'h0, m_ip});
        chk("R5 cs", cs_o, 32'h2000);
        chk("R4 phys inc", phys_addr, {12'h0, phys_of(16'h2000, m_ip)});
        chk("R7 inc no flush", flush_o, 0);
      end
    end
    inc_req = 0;

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule